// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one read or write command into the per-beat column addresses and data-path strobes of a synchronous DRAM burst. It takes a start column, a burst length code and a burst order with the command. It then steps through the beats of the burst, one per clock. While a write beat is active it raises a write-capture strobe. Read beats appear on a read-valid strobe after the programmed CAS latency. Byte-mask inputs are turned into a write-mask strobe with no added delay and a read output-enable with a two-clock delay.

A new command may arrive on any clock, including the clock right after the previous one. It abandons the running burst and starts again from beat 0. A stop pulse ends any burst. A full-page burst runs on, wrapping inside the page, until a stop or a new command arrives. The CAS latency select is a mode input. It is changed only while no read data is in flight. Length and order are latched with each command.

Top module: `sdram_burst_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, all outputs are 0.
- R2: A command sampled at a clock edge gives `col_valid` high from the next cycle for a fixed number of cycles, one beat each. `burst_len` codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. Code 7 is full page. Codes 4 to 6 give 1 beat.
- R3: Sequential order: with burst length L and start column S, beat i presents the column (S - S mod L) + ((S mod L + i) mod L).
- R4: Interleaved order (`interleave`=1): beat i presents (S - S mod L) + ((S mod L) XOR i). For a full-page burst, `interleave` has no effect.
- R5: Full page: beat i presents (S + i) mod 2^COL_W. The beats continue without end until a stop or a new command.
- R6: A `burst_stop` sampled without a command drops `col_valid` and `wr_capture` from the next cycle. When a command and a stop are sampled together, the command wins.
- R7: A command sampled while a burst is running restarts the sequence, so beat 0 of the new burst appears in the next cycle.
- R8: `rd_valid` repeats the pattern of read beats delayed by 2 clocks (`cas3`=0) or 3 clocks (`cas3`=1). After a stop on a read, it therefore falls that many clocks after the last beat.
- R9: `wr_capture` is high exactly during write beats. `wr_mask` is high during a write beat whose `dqm` was sampled high at the edge that opened that beat.
- R10: `rd_oe` equals `rd_valid`, except that it is 0 in every cycle opened two clock edges after an edge where `dqm` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Start a burst this edge |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| start_col | input | COL_W | Start column of the burst |
| burst_len | input | 3 | Length code (see R2) |
| interleave | input | 1 | 1 = interleaved order |
| cas3 | input | 1 | 0 = CAS latency 2, 1 = CAS latency 3 |
| burst_stop | input | 1 | Terminate the running burst |
| dqm | input | 1 | Byte mask sample |
| col_out | output | COL_W | Column of the current beat |
| col_valid | output | 1 | A beat is active |
| wr_capture | output | 1 | Write beat: capture data |
| wr_mask | output | 1 | Current write beat is masked |
| rd_valid | output | 1 | Read data valid |
| rd_oe | output | 1 | Read data driven (not masked) |

## Verification
The hardest situations to reach are a full-page burst that runs past the top of the page, and a stop on a read that lands while earlier beats are still in the latency pipeline. In both, the columns and strobes have to stay correct over many clocks after the triggering input. The stimulus starts a full-page write a few columns below the page end with interleave requested. It lets the burst wrap to column 0 before stopping it. It stops reads in the middle under both latencies. It also issues back-to-back commands and a command together with a stop. A behavioural model in the bench checks every output on every clock.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       burst_len,
  input  logic             interleave,
  input  logic             cas3,
  input  logic             burst_stop,
  input  logic             dqm,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             wr_capture,
  output logic             wr_mask,
  output logic             rd_valid,
  output logic             rd_oe
);
  localparam int RD_PIPE = 3;

  logic             active, is_wr, full, il;
  logic [COL_W-1:0] base, cnt, span;
  logic [COL_W-1:0] new_span;
  logic             new_full;
  logic [RD_PIPE:1] rd_pipe, dqm_pipe;

  always_comb begin
    new_full = 1'b0;
    case (burst_len)
      3'd1:    new_span = COL_W'(1);
      3'd2:    new_span = COL_W'(3);
      3'd3:    new_span = COL_W'(7);
      3'd7:    begin new_span = '1; new_full = 1'b1; end
      default: new_span = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; is_wr <= 1'b0; full <= 1'b0; il <= 1'b0;
      base <= '0; cnt <= '0; span <= '0;
    end else if (cmd_valid) begin
      active <= 1'b1;
      is_wr  <= cmd_write;
      full   <= new_full;
      il     <= interleave & ~new_full;
      base   <= start_col;
      span   <= new_span;
      cnt    <= '0;
    end else if (burst_stop) begin
      active <= 1'b0;
    end else if (active) begin
      if (!full && cnt == span) active <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pipe  <= '0;
      dqm_pipe <= '0;
    end else begin
      rd_pipe  <= {rd_pipe[RD_PIPE-1:1], active & ~is_wr};
      dqm_pipe <= {dqm_pipe[RD_PIPE-1:1], dqm};
    end
  end

  assign col_out    = (base & ~span) | ((il ? (base ^ cnt) : (base + cnt)) & span);
  assign col_valid  = active;
  assign wr_capture = active & is_wr;
  assign wr_mask    = active & is_wr & dqm_pipe[1];
  assign rd_valid   = cas3 ? rd_pipe[3] : rd_pipe[2];
  assign rd_oe      = rd_valid & ~dqm_pipe[3];

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (col_valid && col_out == $past(start_col)));

  // R6
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_stop && !cmd_valid) |=> (!col_valid && !wr_capture));

  // R3
  block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !cmd_valid && !burst_stop && !full) |=>
      (!col_valid || ((col_out & ~span) == ($past(col_out) & ~span))));

  // R5
  fullpage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && full && !burst_stop && !cmd_valid) |=> col_valid);

  // R8
  cl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !wr_capture && !cas3) |-> ##2 rd_valid);

  // R8
  cl3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !wr_capture && cas3) |-> ##3 rd_valid);
endmodule

// File: tb/tb_sdram_burst_seq.sv
module tb_sdram_burst_seq;
  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0, interleave = 0, cas3 = 0, burst_stop = 0, dqm = 0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] burst_len = '0;
  logic [COL_W-1:0] col_out;
  logic col_valid, wr_capture, wr_mask, rd_valid, rd_oe;

  int vectors = 0, errors = 0;

  // model state
  bit m_act = 0, m_wr = 0, m_il = 0;
  int m_start = 0, m_len = 1, m_i = 0;
  bit p1 = 0, p2 = 0, p3 = 0, d1 = 0, d2 = 0, d3 = 0;

  always #4 clk = ~clk;

  sdram_burst_seq #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .start_col(start_col), .burst_len(burst_len), .interleave(interleave),
    .cas3(cas3), .burst_stop(burst_stop), .dqm(dqm), .col_out(col_out),
    .col_valid(col_valid), .wr_capture(wr_capture), .wr_mask(wr_mask),
    .rd_valid(rd_valid), .rd_oe(rd_oe));

  function automatic int exp_col(int s, int len, bit ilv, int i);
    int b, lo;
    if (len == 0) return (s + i) % PAGE;
    lo = s % len;
    b  = s - lo;
    return ilv ? b + (lo ^ i) : b + ((lo + i) % len);
  endfunction

  function automatic int len_of(int code);
    if (code <= 3) return 1 << code;
    if (code == 7) return 0;
    return 1;
  endfunction

  task automatic chk(string req, string name, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit rv;
    rv = cas3 ? p3 : p2;
    chk("R2", "col_valid", col_valid, m_act);
    if (m_act) chk(m_len == 0 ? "R5" : (m_il ? "R4" : "R3"), "col_out",
                   col_out, exp_col(m_start, m_len, m_il, m_i));
    chk("R9", "wr_capture", wr_capture, m_act && m_wr);
    chk("R9", "wr_mask", wr_mask, m_act && m_wr && d1);
    chk("R8", "rd_valid", rd_valid, rv);
    chk("R10", "rd_oe", rd_oe, rv && !d3);
  endtask

  // one clock: check current window, drive inputs, advance model, cross the edge
  task automatic cyc(bit c, bit w, int s, int bl, bit ilv, bit st, bit dm);
    compare();
    cmd_valid = c; cmd_write = w; start_col = COL_W'(s); burst_len = 3'(bl);
    interleave = ilv; burst_stop = st; dqm = dm;
    p3 = p2; p2 = p1; p1 = m_act && !m_wr;
    d3 = d2; d2 = d1; d1 = dm;
    if (c) begin
      m_act = 1; m_wr = w; m_start = s; m_len = len_of(bl); m_i = 0;
      m_il = ilv && (m_len != 0);
    end else if (st) m_act = 0;
    else if (m_act) begin
      if (m_len != 0 && m_i == m_len - 1) m_act = 0;
      else m_i++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held low during reset
    chk("R1", "col_valid", col_valid, 0);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "wr_capture", wr_capture, 0);
    rst_n = 1'b1;
    idle(2);

    // R3 sequential read BL4, CL2
    cyc(1, 0, 30, 2, 0, 0, 0); idle(6);
    // R4 interleaved write BL8 with masked beats (R9)
    cyc(1, 1, 13, 3, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 1);
    idle(6);
    // R2 lengths 2, 1 and reserved code
    cyc(1, 0, 7, 1, 0, 0, 0); idle(5);
    cyc(1, 0, 9, 0, 1, 0, 0); idle(5);
    cyc(1, 1, 9, 5, 0, 0, 0); idle(4);
    // R10 read BL8 sequential with mask pulses
    cyc(1, 0, 101, 3, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    idle(8);
    // R7 back-to-back commands
    cyc(1, 0, 18, 2, 1, 0, 0);
    cyc(1, 1, 45, 1, 0, 0, 1);
    cyc(1, 0, 60, 3, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 3, 2, 0, 0, 0);
    idle(8);
    // R5 full-page write across page end, interleave ignored, then R6 stop
    cyc(1, 1, PAGE - 4, 7, 1, 0, 0);
    for (int k = 0; k < 9; k++) cyc(0, 0, 0, 0, 0, 0, k == 5);
    cyc(0, 0, 0, 0, 0, 1, 0);
    idle(6);
    // R6 stop a read mid-burst under CL2 (R8)
    cyc(1, 0, 40, 3, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    idle(6);

    cas3 = 1'b1;
    idle(2);
    // R8 CL3 read BL4 interleaved
    cyc(1, 0, 77, 2, 1, 0, 0); idle(7);
    // R5 full-page read, then stop; R8 trailing valid under CL3
    cyc(1, 0, 5, 7, 0, 0, 0);
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 0, 0, k == 2);
    cyc(0, 0, 0, 0, 0, 1, 0);
    idle(6);
    // R6 command and stop together: command wins
    cyc(1, 0, 200, 3, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 300, 1, 0, 1, 0);
    idle(4);
    // R6 stop a write: capture ends at once
    cyc(1, 1, 512, 3, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    idle(6);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule